// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This peripheral sits on a processor's 8-bit data bus and offers three byte-wide general-purpose ports: A, B and C. Port C is handled as two independent nibbles, low (bits 3:0) and high (bits 7:4). Each of the four groups (A, B, C-low, C-high) can be set as an input or as an output. One configuration word, written on the same bus, sets all four directions together.

The CPU selects one of four registers with a 2-bit offset. Offset 0 is port A, offset 1 is port B, offset 2 is port C, and offset 3 is the configuration word. For a group set as an output, its pins carry the value last written to it and its output enables are asserted. For a group set as an input, its output enables are low, and a read of that port samples the live pins.

Software can read port C, mask the input nibble and write it back rotated into the output nibble. This works because a read of C merges the live input nibble with the latched output nibble. Only the basic direction-only operating mode is supported. All bus transfers are synchronous to the clock: a strobe counts only when chip select is high at a rising edge.

Top module: `pio3_top`

## Requirements
- R1: After reset, all four groups are inputs, every output enable is low and every output latch holds zero.
- R2: A write with cs and wr high at a rising edge stores wdata into the register selected by addr: 0 = port A latch, 1 = port B latch, 2 = port C latch, 3 = configuration word. A read of offset 3 returns 0x00.
- R3: Configuration direction bits, 1 meaning input and 0 meaning output: bit 4 controls port A, bit 1 port B, bit 0 port C bits 3:0, and bit 3 port C bits 7:4. The output enables of a group are all high when the group is an output and all low when it is an input.
- R4: Configuration word 0x83 makes A and C-high outputs and B and C-low inputs.
- R5: Each port's out pins always show its output latch, and a latch keeps its value until the next write to its offset. A latch is written even while its group is an input.
- R6: A read of port A or B while that port is an input returns the port's input pins as sampled at the read edge. While it is an output, the read returns its latch.
- R7: A read of port C returns each nibble from its input pins if that nibble is an input, and from its latch if that nibble is an output.
- R8: A configuration write with bit 7 clear changes no direction.
- R9: A configuration write with bit 7 set but any of bits 6, 5 or 2 set (a mode other than basic) is ignored entirely.
- R10: rdata is registered. It takes the selected value at the rising edge where cs and rd are high and holds it at all other times.
- R11: While cs is low, wr and rd have no effect on latches, directions or rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data from the CPU |
| rdata | output | 8 | Registered read data to the CPU |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output drivers |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output drivers |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C input pins |
| pc_out | output | 8 | Port C output drivers |
| pc_oe | output | 8 | Port C output enables |

## Verification
A write changes latches, out pins and output enables at the first rising edge with cs and wr high. A read loads rdata at the first rising edge with cs and rd high, so both kinds of result are due one edge after the stimulus. The bench drives each transfer on a falling edge and releases it on the next falling edge. It then samples on that second falling edge, half a cycle after the edge that acted. Input pins are set before the transfer starts and held through the acting edge, so the expected read value is fixed before the edge that samples it.

// File: rtl/pio3_pkg.sv
package pio3_pkg;

  localparam logic [1:0] OFS_A    = 2'd0;
  localparam logic [1:0] OFS_B    = 2'd1;
  localparam logic [1:0] OFS_C    = 2'd2;
  localparam logic [1:0] OFS_CTRL = 2'd3;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cl_in;
    logic cu_in;
  } pio3_dir_t;

  localparam pio3_dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cl_in: 1'b1, cu_in: 1'b1};

  // Accept only a mode-set command that asks for basic mode on both groups
  function automatic logic cw_accept(input logic [7:0] w);
    return w[7] && (w[6:5] == 2'b00) && !w[2];
  endfunction

  function automatic pio3_dir_t cw_dirs(input logic [7:0] w);
    pio3_dir_t d;
    d.a_in  = w[4];
    d.cu_in = w[3];
    d.b_in  = w[1];
    d.cl_in = w[0];
    return d;
  endfunction

  // Per-bit choice between live pin and held latch: mask bit 1 selects pin
  function automatic logic [7:0] pin_or_latch(input logic [7:0] pin,
                                              input logic [7:0] lat,
                                              input logic [7:0] in_mask);
    return (pin & in_mask) | (lat & ~in_mask);
  endfunction

endpackage

// File: rtl/pio3_ctrl.sv
module pio3_ctrl
  import pio3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] cw,
  output logic       cw_taken,
  output pio3_dir_t  dir
);

  assign cw_taken = ctrl_we && cw_accept(cw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dir <= DIR_RESET;
    else if (cw_taken) dir <= cw_dirs(cw);
  end

endmodule

// File: rtl/pio3_port_reg.sv
module pio3_port_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/pio3_rdpath.sv
module pio3_rdpath
  import pio3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_hit,
  input  logic [1:0] addr,
  input  logic [7:0] a_val,
  input  logic [7:0] b_val,
  input  logic [7:0] c_val,
  output logic [7:0] rdata
);

  logic [7:0] sel;

  always_comb begin
    unique case (addr)
      OFS_A:   sel = a_val;
      OFS_B:   sel = b_val;
      OFS_C:   sel = c_val;
      default: sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= 8'h00;
    else if (rd_hit) rdata <= sel;
  end

endmodule

// File: rtl/pio3_top.sv
module pio3_top
  import pio3_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);

  localparam int NPORT = 3;
  localparam int PW    = 8;
  localparam int HALF  = PW / 2;

  // Named bus events, also observed by the checker
  logic wr_hit, rd_hit, ctrl_hit, cw_taken;
  assign wr_hit   = cs && wr;
  assign rd_hit   = cs && rd;
  assign ctrl_hit = wr_hit && (addr == OFS_CTRL);

  pio3_dir_t dir;

  pio3_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_we  (ctrl_hit),
    .cw       (wdata),
    .cw_taken (cw_taken),
    .dir      (dir)
  );

  logic [PW-1:0] lat [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_lat
    pio3_port_reg #(.W(PW)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_hit && (addr == 2'(p))),
      .d     (wdata),
      .q     (lat[p])
    );
  end

  // Direction masks: 1 = bit is an input
  logic [PW-1:0] in_mask_a, in_mask_b, in_mask_c;
  assign in_mask_a = {PW{dir.a_in}};
  assign in_mask_b = {PW{dir.b_in}};
  assign in_mask_c = {{HALF{dir.cu_in}}, {HALF{dir.cl_in}}};

  assign pa_out = lat[0];
  assign pb_out = lat[1];
  assign pc_out = lat[2];
  assign pa_oe  = ~in_mask_a;
  assign pb_oe  = ~in_mask_b;
  assign pc_oe  = ~in_mask_c;

  pio3_rdpath u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_hit (rd_hit),
    .addr   (addr),
    .a_val  (pin_or_latch(pa_in, lat[0], in_mask_a)),
    .b_val  (pin_or_latch(pb_in, lat[1], in_mask_b)),
    .c_val  (pin_or_latch(pc_in, lat[2], in_mask_c)),
    .rdata  (rdata)
  );

endmodule

// File: rtl/pio3_chk.sv
module pio3_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       rd,
  input logic       wr,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pa_in,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe,
  input logic       ctrl_hit
);

  // R3
  oe_group_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(pa_oe) == 0 || $countones(pa_oe) == 8) &&
    ($countones(pb_oe) == 0 || $countones(pb_oe) == 8) &&
    ($countones(pc_oe[3:0]) == 0 || $countones(pc_oe[3:0]) == 4) &&
    ($countones(pc_oe[7:4]) == 0 || $countones(pc_oe[7:4]) == 4));

  // R5
  latch_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && addr == 2'd0) |=> (pa_out == $past(wdata)));

  // R6
  read_a_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && addr == 2'd0 && pa_oe == 8'h00) |=> (rdata == $past(pa_in)));

  // R8
  cmd_bit7_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && !wdata[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  // R9
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_hit && wdata[7] && (wdata[2] || wdata[6:5] != 2'b00))
      |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |=> $stable(rdata));

  // R11
  no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
             $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

endmodule

bind pio3_top pio3_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .rd       (rd),
  .wr       (wr),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .pa_in    (pa_in),
  .pa_out   (pa_out),
  .pa_oe    (pa_oe),
  .pb_out   (pb_out),
  .pb_oe    (pb_oe),
  .pc_out   (pc_out),
  .pc_oe    (pc_oe),
  .ctrl_hit (ctrl_hit)
);

// File: tb/pio3_top_test.sv
`timescale 1ns/1ps
module pio3_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pio3_top uut (.*);

  // Bench model
  logic [7:0] m_lat [3];
  logic       m_a_in, m_b_in, m_cl_in, m_cu_in;

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    logic [7:0] r;
    case (a)
      2'd0: r = m_a_in ? pa_in : m_lat[0];
      2'd1: r = m_b_in ? pb_in : m_lat[1];
      2'd2: begin
        r[3:0] = m_cl_in ? pc_in[3:0] : m_lat[2][3:0];
        r[7:4] = m_cu_in ? pc_in[7:4] : m_lat[2][7:4];
      end
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] exp_oe_c();
    return {m_cu_in ? 4'h0 : 4'hF, m_cl_in ? 4'h0 : 4'hF};
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    if (a != 2'd3) m_lat[a] = d;
    else if (d[7] && d[6:5] == 2'b00 && !d[2]) begin
      m_a_in = d[4]; m_cu_in = d[3]; m_b_in = d[1]; m_cl_in = d[0];
    end
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_pins(input string tag);
    check({tag, " pa_out"}, pa_out, m_lat[0]);
    check({tag, " pb_out"}, pb_out, m_lat[1]);
    check({tag, " pc_out"}, pc_out, m_lat[2]);
    check({tag, " pa_oe"}, pa_oe, m_a_in ? 8'h00 : 8'hFF);
    check({tag, " pb_oe"}, pb_oe, m_b_in ? 8'h00 : 8'hFF);
    check({tag, " pc_oe"}, pc_oe, exp_oe_c());
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    if (sel) model_write(a, d);
  endtask

  task automatic bus_read(input logic [1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    e = exp_read(a);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    check(tag, rdata, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd1234));
    m_lat[0] = 0; m_lat[1] = 0; m_lat[2] = 0;
    m_a_in = 1; m_b_in = 1; m_cl_in = 1; m_cu_in = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pins("R1 reset");
    check("R10 rdata reset", rdata, 8'h00);
    pa_in = 8'h3C; pb_in = 8'hA5; pc_in = 8'h96;
    bus_read(2'd0, "R1 R6 read A input");
    bus_read(2'd2, "R1 R7 read C all input");

    // R4: 0x83 -> A out, B in, C-low in, C-high out
    bus_write(2'd3, 8'h83, 1'b1);
    check("R4 pa_oe", pa_oe, 8'hFF);
    check("R4 pb_oe", pb_oe, 8'h00);
    check("R4 pc_oe", pc_oe, 8'hF0);

    // R2 R5: latch writes
    bus_write(2'd0, 8'h5A, 1'b1);
    check("R2 R5 pa_out", pa_out, 8'h5A);
    bus_write(2'd2, 8'hC3, 1'b1);
    check("R2 pc_out", pc_out, 8'hC3);
    bus_write(2'd1, 8'h77, 1'b1);
    check("R5 pb latch while input", pb_out, 8'h77);
    check("R5 pa_out held", pa_out, 8'h5A);

    // R6 / R7 mixed reads
    pb_in = 8'h19; pc_in = 8'h4E;
    bus_read(2'd1, "R6 read B pins");
    bus_read(2'd0, "R6 read A latch");
    bus_read(2'd2, "R7 read C mixed");
    check("R7 C mixed value", rdata, 8'hCE);
    bus_read(2'd3, "R2 read ctrl offset");

    // R8: bit 7 clear ignored
    bus_write(2'd3, 8'h00, 1'b1);
    check_pins("R8 bit7 clear");
    // R9: nonbasic modes ignored
    bus_write(2'd3, 8'hE0, 1'b1);
    check_pins("R9 mode bits 6:5");
    bus_write(2'd3, 8'h84, 1'b1);
    check_pins("R9 mode bit 2");

    // R3: each direction bit alone
    bus_write(2'd3, 8'h90, 1'b1);
    check("R3 bit4 A in", pa_oe, 8'h00);
    check("R3 bit4 others out", pc_oe, 8'hFF);
    bus_write(2'd3, 8'h88, 1'b1);
    check("R3 bit3 C-high in", pc_oe, 8'h0F);
    bus_write(2'd3, 8'h81, 1'b1);
    check("R3 bit0 C-low in", pc_oe, 8'hF0);
    bus_write(2'd3, 8'h82, 1'b1);
    check("R3 bit1 B in", pb_oe, 8'h00);

    // R11: no effect without cs
    bus_write(2'd0, 8'hEE, 1'b0);
    bus_write(2'd3, 8'h9B, 1'b0);
    check_pins("R11 no cs write");
    held = rdata;
    @(negedge clk); cs = 1'b0; rd = 1'b1; addr = 2'd1; pb_in = ~pb_in;
    @(negedge clk); rd = 1'b0;
    check("R11 R10 rdata held", rdata, held);

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        logic [1:0] a;
        logic [7:0] d;
        a = 2'($urandom);
        d = 8'($urandom);
        if (a == 2'd3 && $urandom_range(0, 1) == 1) d = d & 8'h9B | 8'h80;
        bus_write(a, d, $urandom_range(0, 7) != 0);
        check_pins("R2 R3 R5 random write");
      end else begin
        bus_read(2'($urandom), "R6 R7 random read");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule